// File: doc/BRIEF.md
# Multiword DMA Host Burst Sequencer

This block is the host side of a multiword DMA burst on a parallel ATA style bus with a 16-bit data path. After a start pulse it raises the DMA acknowledge and keeps the chip selects negated. It then issues one read or write strobe per word for as long as the device holds its request line high and the programmed word count has not run out. The timing for each of modes 0 to 2 is built in: strobe active width, recovery width, total cycle time, acknowledge setup and hold, and write data hold. Every nanosecond minimum becomes a clock count, rounded up, from a clock-period parameter.

On the system side, words move over valid/ready handshakes. For writes, a word transfers when `wr_valid` and `wr_ready` are both high at a clock edge. `wr_ready` is high only in the single decision cycle that comes before a strobe. A source with no word ready therefore holds the bus in recovery, and the strobe stays negated. For reads, the word sampled at the end of a strobe is held on `rd_data` with `rd_valid` high until `rd_ready` takes it. While that word is still held and not being taken, no further read strobe is issued. Back-pressure on either side only lengthens the negated time. Active widths never change.

The device request is checked once recovery has elapsed, at the point where the next strobe would start. If the request is low there, the burst ends. The acknowledge hold time then runs, and `done` pulses once in the cycle the acknowledge is released.

Top module: `mwdma_host_seq`

## Requirements
- R1: After reset, `bus_ack_n`, `bus_rd_n` and `bus_wr_n` are 1, `bus_d_oe`, `busy`, `done` and `rd_valid` are 0.
- R2: Each strobe stays low (active) for exactly ceil(A/CLK_NS) cycles, where A is 215, 80 or 70 ns for modes 0, 1 and 2.
- R3: With the system side ready, the negated gap between strobes of one burst is exactly max(ceil(N/CLK_NS), ceil(C/CLK_NS) - act, ceil(L/CLK_NS) - act) cycles. Here act is the R2 count, C is 480/150/120 ns, and N is 50/50/25 ns for reads or 215/50/25 ns for writes. L is 120/40/35 ns for reads or 40/40/35 ns for writes.
- R4: `bus_ack_n` goes low ceil(S/CLK_NS) cycles before the first strobe, where S is 50/30/25 ns. No strobe is ever active while `bus_ack_n` is high.
- R5: After the last strobe of a burst that runs out its word count, `bus_ack_n` stays low for max(ceil(20|5|5), ceil(15|10|10), ceil(20|15|10)) cycles (ns per mode, divided by CLK_NS). `done` pulses for one cycle as `bus_ack_n` returns high.
- R6: A burst issues exactly `word_count` strobes when the request stays high.
- R7: If `bus_req` is low at the decision point, no further strobe is issued. The acknowledge is then held for the R5 count and `done` pulses. If the request is already low at the first decision point, no strobe is issued at all.
- R8: In a write burst (`rd_dir`=0), each word accepted on `wr_data` appears on `bus_d_out`, with `bus_d_oe`=1, from its strobe's assertion and stays stable through that strobe. Words go out in acceptance order.
- R9: In a read burst (`rd_dir`=1), `bus_d_in` is sampled at the last active cycle of each strobe. The word is shown on `rd_data` with `rd_valid`=1 and held stable until `rd_ready` is high.
- R10: No write strobe is issued while `wr_valid` is 0, and no read strobe while an untaken read word is held. The strobe starts on the cycle after the blocking condition clears.
- R11: Mode value 3 gives the same timing as mode 2.
- R12: `bus_cs_n` is 2'b11 in every cycle.
- R13: `start` is ignored while `busy` is 1. A start with `word_count`=0 pulses `done` on the next cycle without asserting the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (sampled while idle) |
| mode | input | 2 | Timing mode 0..2 (3 acts as 2) |
| rd_dir | input | 1 | 1 = device to system, 0 = system to device |
| word_count | input | CNT_W | Words in the burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| wr_data | input | DATA_W | Write word from system |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Write word taken this cycle when valid |
| rd_data | output | DATA_W | Read word to system |
| rd_valid | output | 1 | Read word held |
| rd_ready | input | 1 | System takes read word |
| bus_req | input | 1 | Device DMA request |
| bus_ack_n | output | 1 | DMA acknowledge, active low |
| bus_cs_n | output | 2 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_d_in | input | DATA_W | Bus data from device |
| bus_d_out | output | DATA_W | Bus data to device |
| bus_d_oe | output | 1 | Host drives bus data |

## Verification
The bench builds the block with CLK_NS=10, CNT_W=8 and DATA_W=16. It sweeps every mode value 0 to 3, both directions and word counts 1 to 3, and measures every active run, every recovery gap, the acknowledge lead and the acknowledge tail against counts it derives from the nanosecond minimums. At a 10 ns clock the cycle-time minimum sets the recovery in all three modes, so the same gap is expected for reads and writes. The 3-as-2 alias is covered by the sweep. Dedicated runs cover a request dropped mid-burst, a request low from the start, write starvation, a stalled read sink, a zero-length start and a start issued while busy.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOV,
    ST_HOLD
  } seq_st_e;

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimums in ns, index 0..2; any larger index behaves as 2
  function automatic int pick(input int m, input int v0, input int v1, input int v2);
    return (m == 0) ? v0 : (m == 1) ? v1 : v2;
  endfunction

  function automatic int act_clk(input int m, input int p);
    return cdiv(pick(m, 215, 80, 70), p);
  endfunction

  function automatic int rest_clk(input int m, input int rd, input int p);
    int a, neg, cyc, lat;
    a   = act_clk(m, p);
    neg = cdiv(rd != 0 ? pick(m, 50, 50, 25) : pick(m, 215, 50, 25), p);
    cyc = cdiv(pick(m, 480, 150, 120), p) - a;
    lat = cdiv(rd != 0 ? pick(m, 120, 40, 35) : pick(m, 40, 40, 35), p) - a;
    return imax(neg, imax(cyc, lat));
  endfunction

  function automatic int setup_clk(input int m, input int p);
    return cdiv(pick(m, 50, 30, 25), p);
  endfunction

  function automatic int hold_clk(input int m, input int p);
    return imax(cdiv(pick(m, 20, 5, 5), p),
                imax(cdiv(pick(m, 15, 10, 10), p), cdiv(pick(m, 20, 15, 10), p)));
  endfunction

endpackage

// File: rtl/mwdma_timing.sv
module mwdma_timing #(
  parameter int CLK_NS = 10,
  parameter int TMR_W  = 8
) (
  input  logic [1:0]       mode,
  input  logic             rd,
  output logic [TMR_W-1:0] n_act,
  output logic [TMR_W-1:0] n_rest,
  output logic [TMR_W-1:0] n_setup,
  output logic [TMR_W-1:0] n_hold
);
  localparam int NMODE = 4;

  logic [TMR_W-1:0] act_t   [NMODE];
  logic [TMR_W-1:0] setup_t [NMODE];
  logic [TMR_W-1:0] hold_t  [NMODE];
  logic [TMR_W-1:0] rest_t  [2*NMODE];

  for (genvar g = 0; g < NMODE; g++) begin : g_mode
    localparam int A  = mwdma_pkg::act_clk(g, CLK_NS);
    localparam int S  = mwdma_pkg::setup_clk(g, CLK_NS);
    localparam int H  = mwdma_pkg::hold_clk(g, CLK_NS);
    localparam int RW = mwdma_pkg::rest_clk(g, 0, CLK_NS);
    localparam int RR = mwdma_pkg::rest_clk(g, 1, CLK_NS);
    assign act_t[g]       = TMR_W'(A);
    assign setup_t[g]     = TMR_W'(S);
    assign hold_t[g]      = TMR_W'(H);
    assign rest_t[2*g]    = TMR_W'(RW);
    assign rest_t[2*g+1]  = TMR_W'(RR);
  end

  assign n_act   = act_t[mode];
  assign n_setup = setup_t[mode];
  assign n_hold  = hold_t[mode];
  assign n_rest  = rest_t[{mode, rd}];
endmodule

// File: rtl/mwdma_engine.sv
module mwdma_engine #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              rd_dir,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [TMR_W-1:0]  n_act,
  input  logic [TMR_W-1:0]  n_rest,
  input  logic [TMR_W-1:0]  n_setup,
  input  logic [TMR_W-1:0]  n_hold,
  output logic [1:0]        cfg_mode,
  output logic              cfg_rd,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              bus_req,
  output logic              ack,
  output logic              rd_stb,
  output logic              wr_stb,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe
);
  import mwdma_pkg::*;

  localparam int MON_W = 16;

  seq_st_e          st;
  logic [TMR_W-1:0] cnt;
  logic [CNT_W-1:0] rem;
  logic [1:0]       mode_q;
  logic             dir_q;
  logic             done_q;
  logic             rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] d_out_q;
  logic             d_oe_q;

  logic decide, sys_ok;

  assign cfg_mode = (st == ST_IDLE) ? mode   : mode_q;
  assign cfg_rd   = (st == ST_IDLE) ? rd_dir : dir_q;

  assign decide = (st == ST_SETUP || st == ST_RECOV) && (cnt == '0);
  assign sys_ok = dir_q ? (!rd_valid_q || rd_ready) : wr_valid;

  assign wr_ready  = decide && bus_req && !dir_q;
  assign busy      = (st != ST_IDLE);
  assign ack       = busy;
  assign rd_stb    = (st == ST_ACTIVE) && dir_q;
  assign wr_stb    = (st == ST_ACTIVE) && !dir_q;
  assign done      = done_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign bus_d_out = d_out_q;
  assign bus_d_oe  = d_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      rem        <= '0;
      mode_q     <= '0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      d_out_q    <= '0;
      d_oe_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (word_count == '0) begin
              done_q <= 1'b1;
            end else begin
              st     <= ST_SETUP;
              cnt    <= n_setup - 1'b1;
              rem    <= word_count;
              dir_q  <= rd_dir;
              mode_q <= mode;
            end
          end
        end
        ST_SETUP, ST_RECOV: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!bus_req) begin
            st  <= ST_HOLD;
            cnt <= n_hold - 1'b1;
          end else if (sys_ok) begin
            st  <= ST_ACTIVE;
            cnt <= n_act - 1'b1;
            if (!dir_q) begin
              d_out_q <= wr_data;
              d_oe_q  <= 1'b1;
            end
          end
        end
        ST_ACTIVE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            rem <= rem - 1'b1;
            if (dir_q) begin
              rd_data_q  <= bus_d_in;
              rd_valid_q <= 1'b1;
            end
            if (rem == CNT_W'(1)) begin
              st  <= ST_HOLD;
              cnt <= n_hold - 1'b1;
            end else begin
              st  <= ST_RECOV;
              cnt <= n_rest - 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            d_oe_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // run-length monitors for the strobe, kept apart from the sequencer counter
  logic             stb_any;
  logic             seen_stb;
  logic [MON_W-1:0] hi_len, lo_len;
  assign stb_any = rd_stb || wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len   <= '0;
      lo_len   <= '0;
      seen_stb <= 1'b0;
    end else begin
      hi_len   <= stb_any ? hi_len + 1'b1 : '0;
      lo_len   <= stb_any ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
      seen_stb <= ack && (seen_stb || stb_any);
    end
  end

  AST_ACT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_any) |-> hi_len == MON_W'(n_act)); // R2
  AST_REC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb_any) && seen_stb) |-> lo_len >= MON_W'(n_rest)); // R3
  AST_STB_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stb_any |-> ack); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ack); // R5
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> ($stable(bus_d_out) && bus_d_oe)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_WR_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !dir_q && !wr_valid) |=> !wr_stb); // R10
endmodule

// File: rtl/mwdma_host_seq.sv
module mwdma_host_seq #(
  parameter int CLK_NS = 10,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter int TMR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              rd_dir,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              bus_req,
  output logic              bus_ack_n,
  output logic [1:0]        bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  input  logic [DATA_W-1:0] bus_d_in,
  output logic [DATA_W-1:0] bus_d_out,
  output logic              bus_d_oe
);
  logic [TMR_W-1:0] n_act, n_rest, n_setup, n_hold;
  logic [1:0]       cfg_mode;
  logic             cfg_rd;
  logic             ack, rd_stb, wr_stb;

  mwdma_timing #(.CLK_NS(CLK_NS), .TMR_W(TMR_W)) u_timing (
    .mode    (cfg_mode),
    .rd      (cfg_rd),
    .n_act   (n_act),
    .n_rest  (n_rest),
    .n_setup (n_setup),
    .n_hold  (n_hold)
  );

  mwdma_engine #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .rd_dir     (rd_dir),
    .word_count (word_count),
    .n_act      (n_act),
    .n_rest     (n_rest),
    .n_setup    (n_setup),
    .n_hold     (n_hold),
    .cfg_mode   (cfg_mode),
    .cfg_rd     (cfg_rd),
    .busy       (busy),
    .done       (done),
    .wr_data    (wr_data),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .bus_req    (bus_req),
    .ack        (ack),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .bus_d_in   (bus_d_in),
    .bus_d_out  (bus_d_out),
    .bus_d_oe   (bus_d_oe)
  );

  assign bus_ack_n = !ack;
  assign bus_rd_n  = !rd_stb;
  assign bus_wr_n  = !wr_stb;
  assign bus_cs_n  = 2'b11;
endmodule

// File: tb/mwdma_host_seq_bench.sv
module mwdma_host_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd_dir = 0, wr_valid = 1, rd_ready = 1, bus_req = 1;
  logic [1:0] mode = 0;
  logic [7:0] word_count = 0;
  logic [15:0] wr_data, rd_data, bus_d_in, bus_d_out;
  logic busy, done, wr_ready, rd_valid, bus_ack_n, bus_rd_n, bus_wr_n, bus_d_oe;
  logic [1:0] bus_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int nstb = 0, run = 0, setup_len = 0, hold_len = 0, nrd = 0, wacc = 0, cs_bad = 0;
  int hi [16];
  int lo [16];
  int wdat [16];
  int woe [16];
  int rdat [16];
  bit p_ack = 0, p_stb = 0, hs = 0;

  assign wr_data  = 16'h3C00 + 16'(wacc);
  assign bus_d_in = 16'hA500 + 16'(nstb);

  mwdma_host_seq #(.CLK_NS(CLK_NS)) u_mwdma_host_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd_dir(rd_dir),
    .word_count(word_count), .busy(busy), .done(done), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .bus_req(bus_req), .bus_ack_n(bus_ack_n), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_d_in(bus_d_in),
    .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe)
  );

  // expected counts from the nanosecond minimums
  function automatic int cd(input int n); return (n + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int sel(input int m, input int a, input int b, input int c);
    return (m == 0) ? a : (m == 1) ? b : c;
  endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
  function automatic int e_act(input int m); return cd(sel(m, 215, 80, 70)); endfunction
  function automatic int e_rest(input int m, input int rd);
    int a;
    a = e_act(m);
    return mx(cd(rd ? sel(m, 50, 50, 25) : sel(m, 215, 50, 25)),
              mx(cd(sel(m, 480, 150, 120)) - a, cd(rd ? sel(m, 120, 40, 35) : sel(m, 40, 40, 35)) - a));
  endfunction
  function automatic int e_setup(input int m); return cd(sel(m, 50, 30, 25)); endfunction
  function automatic int e_hold(input int m);
    return mx(cd(sel(m, 20, 5, 5)), mx(cd(sel(m, 15, 10, 10)), cd(sel(m, 20, 15, 10))));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor
  always @(negedge clk) begin
    bit ack, stb;
    ack = !bus_ack_n;
    stb = !bus_rd_n || !bus_wr_n;
    cycles++;
    if (bus_cs_n != 2'b11) cs_bad++;
    if (hs) begin wacc++; hs = 0; end
    if (wr_valid && wr_ready) hs = 1;
    if (rd_valid && rd_ready && nrd < 16) begin rdat[nrd] = rd_data; nrd++; end
    if (ack) begin
      if (!p_ack) begin run = 1; nstb = 0; end
      else if (stb == p_stb) run++;
      else begin
        if (p_stb) hi[nstb-1] = run;
        else if (nstb == 0) setup_len = run;
        else lo[nstb-1] = run;
        if (stb && nstb < 15) begin
          wdat[nstb] = bus_d_out; woe[nstb] = bus_d_oe; nstb++;
        end
        run = 1;
      end
    end else if (p_ack) hold_len = run;
    p_ack = ack;
    p_stb = stb;
  end

  always @(negedge clk) if (cycles > 150000) begin
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    @(negedge clk);
  endtask

  task automatic launch(input int m, input bit rd, input int cnt);
    @(negedge clk);
    mode = 2'(m); rd_dir = rd; word_count = 8'(cnt);
    wacc = 0; nrd = 0; setup_len = -1; hold_len = -1;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic burst(input int m, input bit rd, input int cnt, input int drop_at, input bit poke);
    bit got;
    launch(m, rd, cnt);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (drop_at > 0 && nstb == drop_at && (!bus_rd_n || !bus_wr_n)) bus_req = 0;
      if (poke && i == 3) begin start = 1; word_count = 8'd7; rd_dir = !rd; end
      if (poke && i == 4) start = 0;
      if (done) got = 1;
    end
    @(negedge clk);
    bus_req = 1;
    chk(got, "R5 done pulse", got, 1);
  endtask

  task automatic check_burst(input int m, input bit rd, input int cnt);
    chk(nstb == cnt, "R6 strobe count", nstb, cnt);
    chk(setup_len == e_setup(m), "R4 ack lead", setup_len, e_setup(m));
    chk(hold_len == e_hold(m), "R5 ack tail", hold_len, e_hold(m));
    for (int k = 0; k < cnt && k < nstb; k++) begin
      chk(hi[k] == e_act(m), (m == 3) ? "R11 active width" : "R2 active width", hi[k], e_act(m));
      if (k > 0) chk(lo[k-1] == e_rest(m, rd), "R3 recovery", lo[k-1], e_rest(m, rd));
      if (rd) chk(rdat[k] == 32'hA500 + k + 1, "R9 read word", rdat[k], 32'hA500 + k + 1);
      else chk(wdat[k] == 32'h3C00 + k && woe[k] == 1, "R8 write word", wdat[k], 32'h3C00 + k);
    end
  endtask

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    chk(bus_ack_n && bus_rd_n && bus_wr_n && !bus_d_oe && !busy && !done && !rd_valid,
        "R1 reset outputs", {bus_ack_n, bus_rd_n, bus_wr_n, bus_d_oe, busy, done, rd_valid}, 7'b1110000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // sweep over mode value, direction and length
    for (int m = 0; m < 4; m++)
      for (int rd = 0; rd < 2; rd++)
        for (int c = 1; c <= 3; c++) begin
          burst(m, rd[0], c, 0, 0);
          check_burst(m, rd[0], c);
        end

    // R13: start while busy is ignored
    burst(0, 0, 3, 0, 1);
    check_burst(0, 0, 3);
    repeat (3) @(negedge clk);
    chk(!busy, "R13 no relaunch", busy, 0);

    // R7: request drops during word 2 of 5
    burst(1, 1, 5, 2, 0);
    chk(nstb == 2, "R7 stop on request low", nstb, 2);
    chk(hold_len == e_rest(1, 1) + e_hold(1), "R7 tail", hold_len, e_rest(1, 1) + e_hold(1));

    // R7: request low from the start
    bus_req = 0;
    launch(2, 0, 3);
    wait_done(got);
    bus_req = 1;
    chk(got && nstb == 0, "R7 no strobe", nstb, 0);
    chk(hold_len == e_setup(2) + e_hold(2), "R7 lead+tail", hold_len, e_setup(2) + e_hold(2));

    // R13: zero word count
    @(negedge clk);
    word_count = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(done && bus_ack_n, "R13 zero count", {done, bus_ack_n}, 2'b11);
    @(negedge clk);

    // R10: write source empty
    wr_valid = 0;
    launch(2, 0, 1);
    repeat (20) @(negedge clk);
    chk(nstb == 0 && bus_wr_n, "R10 write starve", nstb, 0);
    wr_valid = 1;
    @(negedge clk);
    chk(!bus_wr_n, "R10 write resumes", bus_wr_n, 0);
    wait_done(got);
    chk(got && nstb == 1 && wdat[0] == 16'h3C00, "R8 starved word", wdat[0], 16'h3C00);

    // R10/R9: read sink stalled
    rd_ready = 0;
    launch(2, 1, 2);
    repeat (40) @(negedge clk);
    chk(nstb == 1 && rd_valid && rd_data == 16'hA501, "R9 held read word", rd_data, 16'hA501);
    chk(bus_rd_n, "R10 read stall", bus_rd_n, 1);
    rd_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!bus_rd_n, "R10 read resumes", bus_rd_n, 0);
    wait_done(got);
    chk(got && nrd == 2 && rdat[1] == 16'hA502, "R9 second word", rdat[1], 16'hA502);

    chk(cs_bad == 0, "R12 chip selects", cs_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule